// File: doc/BRIEF.md
# Spare-Cell Remapping Table Controller

Each processing cell in a small grid keeps its own full copy of a mapping from function identifier to physical cell. A cell that no function is bound to, and that has not been declared faulty, serves as a spare. This controller holds one such copy. It resolves outgoing packet destinations by function identifier. It also repairs the mapping when a fault is reported against a cell.

On a fault report the controller spends one search cycle. In that cycle it finds the non-faulty spare with the smallest Manhattan distance to the failed cell, rebinds the failed cell's function to it, and marks the failed cell dead. The change is committed to the table in a single clock edge and is sent out as an update message, so that every other copy can apply the same change. Update messages from other cells are applied through a separate input. Once the table has been repaired, traffic for the moved function goes to the spare, and no lookup can resolve to the dead cell.

Top module: `remap_ctrl`

## Requirements
- R1: After reset, function f is bound to cell f, no cell is dead, and lk_rvalid, upd_out_valid, busy and no_spare are all low.
- R2: A lookup presented with lk_valid high is answered exactly one cycle later, with lk_rvalid high for one cycle. lk_addr is {column[3:0], row[3:0]}, where the cell index i = row*GRID_X + column.
- R3: A fault report is accepted only when busy is low and fault_cell < GRID_X*GRID_Y. Acceptance raises busy for the following cycle. Reports that arrive while busy is high, and out-of-range cell numbers, are ignored.
- R4: The replacement is the spare (not bound, not dead, not the failed cell) with the least Manhattan distance to the failed cell. Ties go to the lowest cell index.
- R5: At the edge that ends the search cycle, the failed cell's function is rebound to the chosen spare and the failed cell is marked dead, both together. A lookup sampled at that same edge returns the old binding. Any later lookup returns the new one.
- R6: Every committed local change produces a single-cycle upd_out_valid pulse in the cycle after the commit. The pulse carries upd_out_bind, upd_out_func, upd_out_cell (new cell) and upd_out_dead (failed cell).
- R7: An incoming update (upd_in_valid) marks upd_in_dead dead and, when upd_in_bind is 1, binds upd_in_func to upd_in_cell. If it arrives during a search cycle, it is applied first and the search repeats one cycle later against the updated table.
- R8: If the failed cell holds a function and no spare remains, no_spare rises and stays high until reset. The table is left unchanged and no update is sent.
- R9: A fault on a spare cell marks it dead and sends an update with upd_out_bind = 0. A fault on a cell that is already dead changes nothing and sends nothing.
- R10: A dead cell is never chosen as a spare, so after repair no lookup resolves to a dead cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_valid | input | 1 | Fault report strobe |
| fault_cell | input | 4 | Index of the failed cell |
| upd_in_valid | input | 1 | Update message from another copy |
| upd_in_bind | input | 1 | Message carries a rebinding |
| upd_in_func | input | 2 | Function to rebind |
| upd_in_cell | input | 4 | New cell for that function |
| upd_in_dead | input | 4 | Cell to mark dead |
| lk_valid | input | 1 | Lookup request |
| lk_func | input | 2 | Function identifier to resolve |
| lk_rvalid | output | 1 | Lookup answer valid |
| lk_addr | output | 8 | Resolved address {column, row} |
| upd_out_valid | output | 1 | Outgoing update message strobe |
| upd_out_bind | output | 1 | Outgoing message carries a rebinding |
| upd_out_func | output | 2 | Rebound function |
| upd_out_cell | output | 4 | Spare now holding it |
| upd_out_dead | output | 4 | Cell declared dead |
| busy | output | 1 | Search cycle in progress |
| no_spare | output | 1 | Sticky flag: spares exhausted |

## Verification
Lookup answers are due one cycle after the request. The scoreboard therefore queues each expected address when the request is driven and pops it on the falling edge that follows the sampling edge. A fault report sets busy on the next cycle. Its result (update message, table change, no_spare) appears one cycle after that, or one cycle later for each incoming update that stalls the search. The fault tasks count these edges explicitly and compare at the matching falling edge. A lookup placed exactly on the commit edge is expected to return the old binding.

// File: rtl/remap_pkg.sv
// Shared types and grid helpers for the remapping controller.
// Assumes cells are numbered row-major: index = row*grid_x + column.
package remap_pkg;

    typedef enum logic {ST_IDLE, ST_SEARCH} ctl_state_t;

    // Column of a cell index.
    function automatic int cell_col(input int idx, input int gx);
        return idx % gx;
    endfunction

    // Row of a cell index.
    function automatic int cell_row(input int idx, input int gx);
        return idx / gx;
    endfunction

endpackage

// File: rtl/remap_table.sv
// Mapping storage: function -> cell binding plus per-cell dead flags,
// and the registered lookup port. One write port; all fields of a write
// commit on the same edge, so a lookup never sees a partial update.
module remap_table import remap_pkg::*; #(
    parameter int GRID_X  = 3,
    parameter int GRID_Y  = 3,
    parameter int NFUNC   = 4,
    parameter int COORD_W = 4,
    localparam int NCELL  = GRID_X * GRID_Y,
    localparam int CIDX_W = $clog2(NCELL),
    localparam int FID_W  = (NFUNC > 1) ? $clog2(NFUNC) : 1,
    localparam int ADDR_W = 2 * COORD_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           wr_bind,
    input  logic [FID_W-1:0]               wr_func,
    input  logic [CIDX_W-1:0]              wr_cell,
    input  logic [CIDX_W-1:0]              wr_dead,
    input  logic                           lk_valid,
    input  logic [FID_W-1:0]               lk_func,
    output logic                           lk_rvalid,
    output logic [ADDR_W-1:0]              lk_addr,
    output logic [NFUNC-1:0][CIDX_W-1:0]   map_o,
    output logic [NCELL-1:0]               dead_o
);

    logic [NFUNC-1:0][CIDX_W-1:0] map_q;
    logic [NCELL-1:0]             dead_q;

    // Table update: reset to identity binding, then single-edge writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NFUNC; f++) map_q[f] <= CIDX_W'(f);
            dead_q <= '0;
        end else if (wr_en) begin
            if (wr_bind) map_q[wr_func] <= wr_cell;
            if (int'(wr_dead) < NCELL) dead_q[wr_dead] <= 1'b1;
        end
    end

    // Lookup: resolve the function to {column,row} one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_rvalid <= 1'b0;
            lk_addr   <= '0;
        end else begin
            lk_rvalid <= lk_valid;
            if (lk_valid)
                lk_addr <= {COORD_W'(cell_col(int'(map_q[lk_func]), GRID_X)),
                            COORD_W'(cell_row(int'(map_q[lk_func]), GRID_X))};
        end
    end

    assign map_o  = map_q;
    assign dead_o = dead_q;

endmodule

// File: rtl/spare_finder.sv
// Combinational search: finds which function the failed cell holds and
// the nearest usable spare (Manhattan distance, lowest index on ties).
// Assumes every binding in map_i is a valid cell index.
module spare_finder import remap_pkg::*; #(
    parameter int GRID_X  = 3,
    parameter int GRID_Y  = 3,
    parameter int NFUNC   = 4,
    localparam int NCELL  = GRID_X * GRID_Y,
    localparam int CIDX_W = $clog2(NCELL),
    localparam int FID_W  = (NFUNC > 1) ? $clog2(NFUNC) : 1
) (
    input  logic [NFUNC-1:0][CIDX_W-1:0] map_i,
    input  logic [NCELL-1:0]             dead_i,
    input  logic [CIDX_W-1:0]            fault_cell,
    output logic                         owner_hit,
    output logic [FID_W-1:0]             owner_func,
    output logic                         spare_hit,
    output logic [CIDX_W-1:0]            spare_cell
);

    logic [NCELL-1:0] owned;

    // Occupancy and owner of the failed cell.
    always_comb begin
        owned      = '0;
        owner_hit  = 1'b0;
        owner_func = '0;
        for (int c = 0; c < NCELL; c++)
            for (int f = 0; f < NFUNC; f++)
                if (map_i[f] == CIDX_W'(c)) owned[c] = 1'b1;
        for (int f = 0; f < NFUNC; f++)
            if (map_i[f] == fault_cell) begin
                owner_hit  = 1'b1;
                owner_func = FID_W'(f);
            end
    end

    // Nearest spare; strict compare keeps the lowest index on ties.
    always_comb begin
        int fx, fy, dx, dy, best;
        fx = cell_col(int'(fault_cell), GRID_X);
        fy = cell_row(int'(fault_cell), GRID_X);
        best       = GRID_X + GRID_Y;
        spare_hit  = 1'b0;
        spare_cell = '0;
        for (int c = 0; c < NCELL; c++) begin
            dx = cell_col(c, GRID_X) - fx;
            dy = cell_row(c, GRID_X) - fy;
            if (dx < 0) dx = -dx;
            if (dy < 0) dy = -dy;
            if (!owned[c] && !dead_i[c] && CIDX_W'(c) != fault_cell &&
                (dx + dy) < best) begin
                best       = dx + dy;
                spare_hit  = 1'b1;
                spare_cell = CIDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/remap_fsm.sv
// Repair sequencer: accepts a fault report, holds one search cycle, then
// commits the rebinding and emits the update message. Incoming updates
// own the write port and stall a pending search by one cycle each.
module remap_fsm import remap_pkg::*; #(
    parameter int GRID_X  = 3,
    parameter int GRID_Y  = 3,
    parameter int NFUNC   = 4,
    localparam int NCELL  = GRID_X * GRID_Y,
    localparam int CIDX_W = $clog2(NCELL),
    localparam int FID_W  = (NFUNC > 1) ? $clog2(NFUNC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [CIDX_W-1:0] fault_cell,
    input  logic              upd_in_valid,
    input  logic              upd_in_bind,
    input  logic [FID_W-1:0]  upd_in_func,
    input  logic [CIDX_W-1:0] upd_in_cell,
    input  logic [CIDX_W-1:0] upd_in_dead,
    input  logic [NCELL-1:0]  dead_i,
    input  logic              owner_hit,
    input  logic [FID_W-1:0]  owner_func,
    input  logic              spare_hit,
    input  logic [CIDX_W-1:0] spare_cell,
    output logic [CIDX_W-1:0] target_cell,
    output logic              wr_en,
    output logic              wr_bind,
    output logic [FID_W-1:0]  wr_func,
    output logic [CIDX_W-1:0] wr_cell,
    output logic [CIDX_W-1:0] wr_dead,
    output logic              upd_out_valid,
    output logic              upd_out_bind,
    output logic [FID_W-1:0]  upd_out_func,
    output logic [CIDX_W-1:0] upd_out_cell,
    output logic [CIDX_W-1:0] upd_out_dead,
    output logic              busy,
    output logic              no_spare
);

    ctl_state_t  state_q;
    logic [CIDX_W-1:0] fc_q;
    logic        local_go;
    logic        commit;

    assign busy        = (state_q == ST_SEARCH);
    assign target_cell = fc_q;
    assign local_go    = busy && !upd_in_valid && !dead_i[fc_q];
    assign commit      = local_go && (!owner_hit || spare_hit);

    // Write-port arbitration: incoming message first, then local repair.
    always_comb begin
        wr_en   = 1'b0;
        wr_bind = 1'b0;
        wr_func = '0;
        wr_cell = '0;
        wr_dead = '0;
        if (upd_in_valid) begin
            wr_en   = 1'b1;
            wr_bind = upd_in_bind;
            wr_func = upd_in_func;
            wr_cell = upd_in_cell;
            wr_dead = upd_in_dead;
        end else if (commit) begin
            wr_en   = 1'b1;
            wr_bind = owner_hit;
            wr_func = owner_func;
            wr_cell = spare_cell;
            wr_dead = fc_q;
        end
    end

    // Sequencer state and captured fault target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fc_q    <= '0;
        end else if (state_q == ST_IDLE) begin
            if (fault_valid && int'(fault_cell) < NCELL) begin
                state_q <= ST_SEARCH;
                fc_q    <= fault_cell;
            end
        end else if (!upd_in_valid) begin
            state_q <= ST_IDLE;
        end
    end

    // Outgoing update message and sticky exhaustion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_out_valid <= 1'b0;
            upd_out_bind  <= 1'b0;
            upd_out_func  <= '0;
            upd_out_cell  <= '0;
            upd_out_dead  <= '0;
            no_spare      <= 1'b0;
        end else begin
            upd_out_valid <= commit;
            if (commit) begin
                upd_out_bind <= owner_hit;
                upd_out_func <= owner_func;
                upd_out_cell <= spare_cell;
                upd_out_dead <= fc_q;
            end
            if (local_go && owner_hit && !spare_hit) no_spare <= 1'b1;
        end
    end

endmodule

// File: rtl/remap_ctrl.sv
// Top: one copy of the function-to-cell mapping with lookup, nearest-spare
// repair and update exchange. Assumes the fault reporter waits while busy.
module remap_ctrl import remap_pkg::*; #(
    parameter int GRID_X  = 3,
    parameter int GRID_Y  = 3,
    parameter int NFUNC   = 4,
    parameter int COORD_W = 4,
    localparam int NCELL  = GRID_X * GRID_Y,
    localparam int CIDX_W = $clog2(NCELL),
    localparam int FID_W  = (NFUNC > 1) ? $clog2(NFUNC) : 1,
    localparam int ADDR_W = 2 * COORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_valid,
    input  logic [CIDX_W-1:0] fault_cell,
    input  logic              upd_in_valid,
    input  logic              upd_in_bind,
    input  logic [FID_W-1:0]  upd_in_func,
    input  logic [CIDX_W-1:0] upd_in_cell,
    input  logic [CIDX_W-1:0] upd_in_dead,
    input  logic              lk_valid,
    input  logic [FID_W-1:0]  lk_func,
    output logic              lk_rvalid,
    output logic [ADDR_W-1:0] lk_addr,
    output logic              upd_out_valid,
    output logic              upd_out_bind,
    output logic [FID_W-1:0]  upd_out_func,
    output logic [CIDX_W-1:0] upd_out_cell,
    output logic [CIDX_W-1:0] upd_out_dead,
    output logic              busy,
    output logic              no_spare
);

    logic [NFUNC-1:0][CIDX_W-1:0] map_w;
    logic [NCELL-1:0]             dead_w;
    logic              wr_en, wr_bind;
    logic [FID_W-1:0]  wr_func, owner_func;
    logic [CIDX_W-1:0] wr_cell, wr_dead, spare_cell, target_cell;
    logic              owner_hit, spare_hit;

    remap_table #(.GRID_X(GRID_X), .GRID_Y(GRID_Y), .NFUNC(NFUNC), .COORD_W(COORD_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bind(wr_bind), .wr_func(wr_func),
        .wr_cell(wr_cell), .wr_dead(wr_dead),
        .lk_valid(lk_valid), .lk_func(lk_func),
        .lk_rvalid(lk_rvalid), .lk_addr(lk_addr),
        .map_o(map_w), .dead_o(dead_w)
    );

    spare_finder #(.GRID_X(GRID_X), .GRID_Y(GRID_Y), .NFUNC(NFUNC)) u_finder (
        .map_i(map_w), .dead_i(dead_w), .fault_cell(target_cell),
        .owner_hit(owner_hit), .owner_func(owner_func),
        .spare_hit(spare_hit), .spare_cell(spare_cell)
    );

    remap_fsm #(.GRID_X(GRID_X), .GRID_Y(GRID_Y), .NFUNC(NFUNC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .fault_valid(fault_valid), .fault_cell(fault_cell),
        .upd_in_valid(upd_in_valid), .upd_in_bind(upd_in_bind),
        .upd_in_func(upd_in_func), .upd_in_cell(upd_in_cell),
        .upd_in_dead(upd_in_dead), .dead_i(dead_w),
        .owner_hit(owner_hit), .owner_func(owner_func),
        .spare_hit(spare_hit), .spare_cell(spare_cell),
        .target_cell(target_cell),
        .wr_en(wr_en), .wr_bind(wr_bind), .wr_func(wr_func),
        .wr_cell(wr_cell), .wr_dead(wr_dead),
        .upd_out_valid(upd_out_valid), .upd_out_bind(upd_out_bind),
        .upd_out_func(upd_out_func), .upd_out_cell(upd_out_cell),
        .upd_out_dead(upd_out_dead),
        .busy(busy), .no_spare(no_spare)
    );

endmodule

// File: rtl/remap_ctrl_chk.sv
// Protocol checker for remap_ctrl, attached by bind. Observes ports only.
module remap_ctrl_chk #(
    parameter int GRID_X  = 3,
    parameter int GRID_Y  = 3,
    parameter int NFUNC   = 4,
    localparam int NCELL  = GRID_X * GRID_Y,
    localparam int CIDX_W = $clog2(NCELL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fault_valid,
    input logic [CIDX_W-1:0] fault_cell,
    input logic              upd_in_valid,
    input logic              lk_valid,
    input logic              lk_rvalid,
    input logic              upd_out_valid,
    input logic              upd_out_bind,
    input logic [CIDX_W-1:0] upd_out_cell,
    input logic [CIDX_W-1:0] upd_out_dead,
    input logic              busy,
    input logic              no_spare
);

    p_lookup_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_rvalid);

    p_lookup_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_rvalid);

    p_fault_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fault_valid && int'(fault_cell) < NCELL) |=> busy);

    p_search_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !upd_in_valid) |=> !busy);

    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && upd_in_valid) |=> (busy && !upd_out_valid));

    p_bcast_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_out_valid |=> !upd_out_valid);

    p_bcast_after_search_r6: assert property (@(posedge clk) disable iff (!rst_n)
        upd_out_valid |-> $past(busy));

    p_spare_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_out_valid && upd_out_bind) |-> (upd_out_cell != upd_out_dead));

    p_no_spare_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        no_spare |=> no_spare);

endmodule

bind remap_ctrl remap_ctrl_chk #(.GRID_X(GRID_X), .GRID_Y(GRID_Y), .NFUNC(NFUNC)) u_chk (.*);

// File: tb/remap_ctrl_test.sv
// Scoreboard bench for remap_ctrl with a reference model of the table.
module remap_ctrl_test;

    localparam int GX = 3, GY = 3, NF = 4, NC = GX * GY;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fault_valid = 1'b0;
    logic [3:0] fault_cell = '0;
    logic       upd_in_valid = 1'b0, upd_in_bind = 1'b0;
    logic [1:0] upd_in_func = '0;
    logic [3:0] upd_in_cell = '0, upd_in_dead = '0;
    logic       lk_valid = 1'b0;
    logic [1:0] lk_func = '0;
    logic       lk_rvalid, upd_out_valid, upd_out_bind, busy, no_spare;
    logic [7:0] lk_addr;
    logic [1:0] upd_out_func;
    logic [3:0] upd_out_cell, upd_out_dead;

    int checks = 0, failures = 0;
    bit done = 0;
    int m_map[NF];
    bit m_dead[NC];
    int exp_q[$];
    string req_q[$];

    remap_ctrl uut (.*);

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int addr_of(input int c);
        return ((c % GX) << 4) | (c / GX);
    endfunction

    function automatic int owner_of(input int c);
        for (int f = 0; f < NF; f++) if (m_map[f] == c) return f;
        return -1;
    endfunction

    function automatic int pick_spare(input int fc);
        int best = 1000, res = -1, d, dx, dy;
        for (int c = 0; c < NC; c++) begin
            dx = (c % GX) - (fc % GX); dy = (c / GX) - (fc / GX);
            d = (dx < 0 ? -dx : dx) + (dy < 0 ? -dy : dy);
            if (owner_of(c) < 0 && !m_dead[c] && c != fc && d < best) begin
                best = d; res = c;
            end
        end
        return res;
    endfunction

    // Monitor: pop expected lookup answers as they appear (R2).
    always @(negedge clk) begin
        if (rst_n && lk_rvalid) begin
            if (exp_q.size() == 0) chk(0, "R2 unexpected answer", int'(lk_addr), -1);
            else begin
                int e; string r;
                e = exp_q.pop_front(); r = req_q.pop_front();
                chk(int'(lk_addr) == e, r, int'(lk_addr), e);
            end
        end
    end

    task automatic lookup(input int f, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_func = 2'(f);
        exp_q.push_back(addr_of(m_map[f])); req_q.push_back(req);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Checks the outgoing message against the model and applies it there.
    task automatic expect_result(input int fc);
        int own, sp;
        own = owner_of(fc);
        sp  = pick_spare(fc);
        if (m_dead[fc]) begin
            chk(upd_out_valid == 0, "R9 dead cell fault sends nothing", int'(upd_out_valid), 0);
        end else if (own >= 0 && sp < 0) begin
            chk(upd_out_valid == 0, "R8 no update when exhausted", int'(upd_out_valid), 0);
            chk(no_spare == 1, "R8 no_spare raised", int'(no_spare), 1);
        end else begin
            chk(upd_out_valid == 1, "R6 update pulse", int'(upd_out_valid), 1);
            chk(upd_out_bind == (own >= 0), "R9 bind flag", int'(upd_out_bind), int'(own >= 0));
            chk(int'(upd_out_dead) == fc, "R6 dead field", int'(upd_out_dead), fc);
            if (own >= 0) begin
                chk(int'(upd_out_cell) == sp, "R4 nearest spare", int'(upd_out_cell), sp);
                chk(int'(upd_out_func) == own, "R6 func field", int'(upd_out_func), own);
                m_map[own] = sp;
            end
            m_dead[fc] = 1;
        end
    endtask

    // Fault report; optional probe lookup on the commit edge, optional held strobe.
    task automatic inject(input int fc, input int probe, input bit hold);
        @(negedge clk);
        fault_valid = 1'b1; fault_cell = 4'(fc);
        @(negedge clk);
        chk(busy == 1, "R3 busy after accept", int'(busy), 1);
        if (!hold) fault_valid = 1'b0;
        if (probe >= 0) begin
            lk_valid = 1'b1; lk_func = 2'(probe);
            exp_q.push_back(addr_of(m_map[probe])); req_q.push_back("R5 old binding on commit edge");
        end
        @(negedge clk);
        lk_valid = 1'b0;
        fault_valid = 1'b0;
        chk(busy == 0, "R3 busy lasts one cycle", int'(busy), 0);
        expect_result(fc);
    endtask

    task automatic apply_in_model(input bit b, input int f, input int c, input int d);
        if (b) m_map[f] = c;
        m_dead[d] = 1;
    endtask

    task automatic send_update(input bit b, input int f, input int c, input int d);
        @(negedge clk);
        upd_in_valid = 1'b1; upd_in_bind = b; upd_in_func = 2'(f);
        upd_in_cell = 4'(c); upd_in_dead = 4'(d);
        @(negedge clk);
        upd_in_valid = 1'b0;
        apply_in_model(b, f, c, d);
    endtask

    // Fault whose search cycle coincides with an incoming update (R7).
    task automatic inject_stalled(input int fc, input int f, input int c, input int d);
        @(negedge clk);
        fault_valid = 1'b1; fault_cell = 4'(fc);
        @(negedge clk);
        fault_valid = 1'b0;
        upd_in_valid = 1'b1; upd_in_bind = 1'b1; upd_in_func = 2'(f);
        upd_in_cell = 4'(c); upd_in_dead = 4'(d);
        @(negedge clk);
        upd_in_valid = 1'b0;
        chk(busy == 1, "R7 search stalled", int'(busy), 1);
        chk(upd_out_valid == 0, "R7 no update during stall", int'(upd_out_valid), 0);
        apply_in_model(1, f, c, d);
        @(negedge clk);
        expect_result(fc);
    endtask

    initial begin
        for (int f = 0; f < NF; f++) m_map[f] = f;
        for (int c = 0; c < NC; c++) m_dead[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lk_rvalid == 0, "R1 lk_rvalid low", int'(lk_rvalid), 0);
        chk(upd_out_valid == 0, "R1 upd_out_valid low", int'(upd_out_valid), 0);
        chk(busy == 0, "R1 busy low", int'(busy), 0);
        chk(no_spare == 0, "R1 no_spare low", int'(no_spare), 0);
        for (int f = 0; f < NF; f++) lookup(f, "R1 identity binding");

        inject(0, -1, 0);
        chk(m_map[0] == 4, "R4 tie goes to lowest index", m_map[0], 4);
        lookup(0, "R5 moved function resolves to spare");

        inject(3, 3, 0);
        lookup(3, "R5 new binding after commit");

        @(negedge clk);
        fault_valid = 1'b1; fault_cell = 4'd12;
        @(negedge clk);
        fault_valid = 1'b0;
        chk(busy == 0, "R3 out-of-range cell ignored", int'(busy), 0);

        inject_stalled(1, 2, 8, 2);
        lookup(2, "R7 incoming rebinding applied");
        lookup(1, "R10 repaired function off dead cell");

        inject(7, -1, 1);
        inject(0, -1, 0);
        send_update(0, 0, 0, 7);
        for (int f = 0; f < NF; f++) lookup(f, "R10 no lookup hits a dead cell");

        inject(4, -1, 0);
        lookup(0, "R8 table unchanged when exhausted");
        repeat (3) @(negedge clk);
        chk(no_spare == 1, "R8 no_spare sticky", int'(no_spare), 1);
        chk(exp_q.size() == 0, "R2 all lookups answered", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule